// File: doc/BRIEF.md
# Core-Local Timer and Software Interrupt Unit

This unit raises machine-level timer and software interrupts for a parameterised number of harts. It keeps one 64-bit time counter shared by all harts, one 64-bit compare value per hart and one software-pending bit per hart. A hart's timer-pending output goes high while the counter is at or above that hart's compare value. A hart's software-pending output follows a bit that any bus master can set or clear.

A simple request/response register bus reaches all state. Each request carries a 32-bit or 64-bit little-endian access with byte strobes. The response comes one cycle later and carries read data and an error flag. A 64-bit access always behaves as two word accesses, to the addressed word and to the word after it. Each half is decoded on its own, so a wide access may span two regions. The counter advances by a programmable amount on every cycle that the tick-enable input is high.

Top module: `tsu_top`

## Requirements
- R1: After reset the time counter is 0, every software-pending bit is 0, every compare value is all ones, and all pending outputs are low.
- R2: On each cycle with `tick_en` high and no write to the counter, the counter increases by `tick_amt`, modulo 2^64.
- R3: The counter's low word sits at byte offset 0xBFF8 and its high word at 0xBFFC. Writes merge under the byte strobes. Any write to either word in a cycle suppresses that cycle's tick.
- R4: `tip_o[i]` is high exactly when the counter is greater than or equal to compare value i, as an unsigned 64-bit compare. It changes on the clock edge after the edge that updated the counter or the compare value.
- R5: Software-pending slot i is the word at offset 4*i. A write whose strobe bit 0 is set loads data bit 0. A write with strobe bit 0 clear leaves the bit unchanged. A read returns the bit in data bit 0 and zeros in all other bits.
- R6: Compare value i occupies offsets 0x4000+8*i (low word) and 0x4004+8*i (high word). Writes merge per byte under the strobes.
- R7: With `req_wide`=1, the access covers the word at the address and the next word. The addressed word uses data bits 31:0 and strobes 3:0, and the next word uses bits 63:32 and strobes 7:4. This holds in every region, including across a region boundary.
- R8: A software-pending slot or compare word of a hart index at or above `NHARTS` reads as zero, and writes to it are dropped.
- R9: Any other offset below 0xC000 reads as zero and ignores writes.
- R10: An access with any word at or above offset 0xC000 returns `rsp_err`=1 with read data zero, and changes no state.
- R11: Every request gets `rsp_valid` on the next cycle, with its read data (zero for writes). Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Advance the counter this cycle |
| tick_amt | input | TICK_W | Amount added per enabled cycle |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit |
| req_addr | input | 16 | Byte offset inside the unit |
| req_strb | input | 8 | Byte write strobes |
| req_wdata | input | 64 | Write data, little-endian |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 64 | Read data |
| rsp_err | output | 1 | Access ran past the window |
| tip_o | output | NHARTS | Timer-pending per hart |
| sip_o | output | NHARTS | Software-pending per hart |

## Verification
A counter write and a tick can land in the same cycle. The bench raises `tick_en` on the same edge that a write to the low counter word is sampled, then reads the counter back and expects the written value, not that value plus the tick. The second overlap is a compare write and the timer-pending output that depends on it. The bench samples `tip_o` between the two edges after the write and expects the old level first and the new level one cycle later.

// File: rtl/tsu_pkg.sv
package tsu_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned WIDX_W = ADDR_W - 1;   // word index plus carry bit
  localparam int unsigned HART_W = 12;

  // word-index landmarks of the fixed map
  localparam logic [WIDX_W-1:0] CMP_BASE_W = 15'h1000;
  localparam logic [WIDX_W-1:0] TIME_LO_W  = 15'h2FFE;
  localparam logic [WIDX_W-1:0] WIN_END_W  = 15'h3000;

  typedef enum logic [2:0] {
    RG_NONE, RG_SIP, RG_CMP, RG_TLO, RG_THI, RG_ERR
  } rgn_e;

  typedef struct packed {
    rgn_e              rgn;
    logic [HART_W-1:0] hart;
    logic              hi;
  } dec_t;
endpackage

// File: rtl/tsu_lane_dec.sv
module tsu_lane_dec
  import tsu_pkg::*;
#(
  parameter int unsigned NHARTS = 4
) (
  input  logic [WIDX_W-1:0] widx_i,
  output dec_t              dec_o
);
  localparam logic [HART_W-1:0] NH = HART_W'(NHARTS);

  logic [12:0] cmp_off;

  always_comb begin
    cmp_off = 13'(widx_i - CMP_BASE_W);
    dec_o   = '{rgn: RG_NONE, hart: '0, hi: 1'b0};
    if (widx_i >= WIN_END_W) begin
      dec_o.rgn = RG_ERR;
    end else if (widx_i < CMP_BASE_W) begin
      dec_o.hart = widx_i[HART_W-1:0];
      if (dec_o.hart < NH) dec_o.rgn = RG_SIP;
    end else if (widx_i < TIME_LO_W) begin
      dec_o.hart = cmp_off[12:1];
      dec_o.hi   = cmp_off[0];
      if (dec_o.hart < NH) dec_o.rgn = RG_CMP;
    end else if (widx_i == TIME_LO_W) begin
      dec_o.rgn = RG_TLO;
    end else begin
      dec_o.rgn = RG_THI;
    end
  end
endmodule

// File: rtl/tsu_hart_slice.sv
module tsu_hart_slice
  import tsu_pkg::*;
#(
  parameter int unsigned HART_ID = 0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [1:0]            lane_we,
  input  dec_t [1:0]            lane_dec,
  input  logic [1:0][3:0]       lane_strb,
  input  logic [1:0][31:0]      lane_wdata,
  input  logic [63:0]           time_i,
  output logic [63:0]           cmp_q,
  output logic                  sip_q,
  output logic                  tip_q
);
  localparam logic [HART_W-1:0] HID = HART_W'(HART_ID);

  logic [63:0] cmp_d;
  logic        sip_d;

  always_comb begin
    cmp_d = cmp_q;
    sip_d = sip_q;
    for (int l = 0; l < 2; l++) begin
      if (lane_we[l] && lane_dec[l].hart == HID) begin
        if (lane_dec[l].rgn == RG_CMP) begin
          for (int b = 0; b < 4; b++) begin
            if (lane_strb[l][b])
              cmp_d[{lane_dec[l].hi, 2'(b), 3'b000} +: 8] = lane_wdata[l][b*8 +: 8];
          end
        end
        if (lane_dec[l].rgn == RG_SIP && lane_strb[l][0])
          sip_d = lane_wdata[l][0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= '1;
      sip_q <= 1'b0;
      tip_q <= 1'b0;
    end else begin
      cmp_q <= cmp_d;
      sip_q <= sip_d;
      tip_q <= (time_i >= cmp_q);
    end
  end
endmodule

// File: rtl/tsu_counter.sv
module tsu_counter #(
  parameter int unsigned TICK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic [TICK_W-1:0] tick_amt,
  input  logic [1:0]        wr_en,
  input  logic [1:0]        wr_hi,
  input  logic [1:0][3:0]   wr_strb,
  input  logic [1:0][31:0]  wr_data,
  output logic [63:0]       time_q
);
  logic [63:0] time_d;

  always_comb begin
    time_d = time_q;
    if (|wr_en) begin
      for (int l = 0; l < 2; l++) begin
        if (wr_en[l]) begin
          for (int b = 0; b < 4; b++) begin
            if (wr_strb[l][b])
              time_d[{wr_hi[l], 2'(b), 3'b000} +: 8] = wr_data[l][b*8 +: 8];
          end
        end
      end
    end else if (tick_en) begin
      time_d = time_q + 64'(tick_amt);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) time_q <= '0;
    else     time_q <= time_d;
  end
endmodule

// File: rtl/tsu_top.sv
module tsu_top
  import tsu_pkg::*;
#(
  parameter int unsigned NHARTS = 4,
  parameter int unsigned TICK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic [TICK_W-1:0] tick_amt,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [15:0]       req_addr,
  input  logic [7:0]        req_strb,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  output logic [63:0]       rsp_rdata,
  output logic              rsp_err,
  output logic [NHARTS-1:0] tip_o,
  output logic [NHARTS-1:0] sip_o
);
  localparam int unsigned HIDX_W = (NHARTS > 1) ? $clog2(NHARTS) : 1;

  logic [WIDX_W-1:0]  lane_widx [2];
  dec_t [1:0]         lane_dec;
  logic [1:0]         lane_used;
  logic [1:0]         lane_we;
  logic [1:0][3:0]    lane_strb;
  logic [1:0][31:0]   lane_wdata;
  logic [1:0][31:0]   lane_rd;
  logic [1:0]         time_wr_en;
  logic [1:0]         time_wr_hi;
  logic               acc_err;
  logic [63:0]        time_q;
  logic [63:0]        cmp_arr [NHARTS];
  logic               unused_addr_lsb;

  assign unused_addr_lsb = ^req_addr[1:0];
  assign lane_widx[0]    = {1'b0, req_addr[15:2]};
  assign lane_widx[1]    = lane_widx[0] + 1'b1;
  assign lane_used       = {req_wide, 1'b1};
  assign acc_err         = req_valid &&
                           (lane_dec[0].rgn == RG_ERR ||
                            (req_wide && lane_dec[1].rgn == RG_ERR));

  for (genvar l = 0; l < 2; l++) begin : g_lane
    tsu_lane_dec #(.NHARTS(NHARTS)) u_dec (
      .widx_i (lane_widx[l]),
      .dec_o  (lane_dec[l])
    );
    assign lane_we[l]    = req_valid && req_write && !acc_err && lane_used[l];
    assign lane_strb[l]  = req_strb[l*4 +: 4];
    assign lane_wdata[l] = req_wdata[l*32 +: 32];
    assign time_wr_en[l] = lane_we[l] &&
                           (lane_dec[l].rgn == RG_TLO || lane_dec[l].rgn == RG_THI);
    assign time_wr_hi[l] = (lane_dec[l].rgn == RG_THI);

    always_comb begin
      lane_rd[l] = '0;
      case (lane_dec[l].rgn)
        RG_SIP: lane_rd[l] = {31'b0, sip_o[lane_dec[l].hart[HIDX_W-1:0]]};
        RG_CMP: lane_rd[l] = lane_dec[l].hi ?
                             cmp_arr[lane_dec[l].hart[HIDX_W-1:0]][63:32] :
                             cmp_arr[lane_dec[l].hart[HIDX_W-1:0]][31:0];
        RG_TLO: lane_rd[l] = time_q[31:0];
        RG_THI: lane_rd[l] = time_q[63:32];
        default: lane_rd[l] = '0;
      endcase
    end
  end

  tsu_counter #(.TICK_W(TICK_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .tick_en  (tick_en),
    .tick_amt (tick_amt),
    .wr_en    (time_wr_en),
    .wr_hi    (time_wr_hi),
    .wr_strb  (lane_strb),
    .wr_data  (lane_wdata),
    .time_q   (time_q)
  );

  for (genvar h = 0; h < NHARTS; h++) begin : g_hart
    tsu_hart_slice #(.HART_ID(h)) u_slice (
      .clk        (clk),
      .rst        (rst),
      .lane_we    (lane_we),
      .lane_dec   (lane_dec),
      .lane_strb  (lane_strb),
      .lane_wdata (lane_wdata),
      .time_i     (time_q),
      .cmp_q      (cmp_arr[h]),
      .sip_q      (sip_o[h]),
      .tip_q      (tip_o[h])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= acc_err;
      if (req_valid && !req_write && !acc_err)
        rsp_rdata <= {lane_used[1] ? lane_rd[1] : 32'h0, lane_rd[0]};
      else
        rsp_rdata <= '0;
    end
  end
endmodule

// File: rtl/tsu_checker.sv
module tsu_checker #(
  parameter int unsigned NHARTS = 4,
  parameter int unsigned TICK_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_en,
  input logic [TICK_W-1:0] tick_amt,
  input logic              req_valid,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [63:0]       rsp_rdata,
  input logic [NHARTS-1:0] tip_o,
  input logic [NHARTS-1:0] sip_o,
  input logic [63:0]       time_q,
  input logic [63:0]       cmp_arr [NHARTS]
);
  // R2: an enabled tick with no write adds the tick amount
  a_r2_tick_adds: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !(req_valid && req_write)) |=>
      time_q == $past(time_q) + 64'($past(tick_amt)));

  // R5: without a write the software-pending bits hold
  a_r5_sip_hold: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_write) |=> $stable(sip_o));

  // R10: an error response carries no data
  a_r10_err_zero: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> rsp_rdata == 64'h0);

  // R11: one response per request, one cycle later
  a_r11_rsp_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r11_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  // R4: timer-pending tracks the registered compare one edge later
  for (genvar h = 0; h < NHARTS; h++) begin : g_tip
    a_r4_tip_follow: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> tip_o[h] == ($past(time_q) >= $past(cmp_arr[h])));
  end
endmodule

bind tsu_top tsu_checker #(.NHARTS(NHARTS), .TICK_W(TICK_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .tick_en   (tick_en),
  .tick_amt  (tick_amt),
  .req_valid (req_valid),
  .req_write (req_write),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .rsp_rdata (rsp_rdata),
  .tip_o     (tip_o),
  .sip_o     (sip_o),
  .time_q    (time_q),
  .cmp_arr   (cmp_arr)
);

// File: tb/tsu_top_tb_top.sv
module tsu_top_tb_top;
  localparam int unsigned NHARTS = 4;
  localparam int unsigned TICK_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              tick_en = 1'b0;
  logic [TICK_W-1:0] tick_amt = '0;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic              req_wide = 1'b0;
  logic [15:0]       req_addr = '0;
  logic [7:0]        req_strb = '0;
  logic [63:0]       req_wdata = '0;
  logic              rsp_valid;
  logic [63:0]       rsp_rdata;
  logic              rsp_err;
  logic [NHARTS-1:0] tip_o;
  logic [NHARTS-1:0] sip_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tsu_top #(.NHARTS(NHARTS), .TICK_W(TICK_W)) dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .tick_amt(tick_amt),
    .req_valid(req_valid), .req_write(req_write), .req_wide(req_wide),
    .req_addr(req_addr), .req_strb(req_strb), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .tip_o(tip_o), .sip_o(sip_o)
  );

  typedef struct packed {
    logic        wr;
    logic        wide;
    logic [15:0] addr;
    logic [7:0]  strb;
    logic [63:0] wdata;
    logic [63:0] exp;
    logic        err;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,16'hBFF8,8'h00,64'h0,64'h0,1'b0,8'd1},                          // R1 counter
    '{1'b0,1'b0,16'h4000,8'h00,64'h0,64'hFFFF_FFFF,1'b0,8'd1},                  // R1 compare
    '{1'b0,1'b1,16'h4000,8'h00,64'h0,64'hFFFF_FFFF_FFFF_FFFF,1'b0,8'd1},        // R1 compare wide
    '{1'b1,1'b0,16'h4000,8'h0F,64'h10,64'h0,1'b0,8'd6},                         // R6 lo
    '{1'b1,1'b0,16'h4004,8'h0F,64'h0,64'h0,1'b0,8'd6},                          // R6 hi
    '{1'b0,1'b1,16'h4000,8'h00,64'h0,64'h10,1'b0,8'd7},                         // R7 wide read
    '{1'b1,1'b0,16'h0004,8'h01,64'h1,64'h0,1'b0,8'd5},                          // R5 set hart1
    '{1'b0,1'b0,16'h0004,8'h00,64'h0,64'h1,1'b0,8'd5},                          // R5
    '{1'b1,1'b0,16'h0008,8'h0E,64'hFFFF_FFFF,64'h0,1'b0,8'd5},                  // R5 byte0 strobe clear
    '{1'b0,1'b0,16'h0008,8'h00,64'h0,64'h0,1'b0,8'd5},                          // R5
    '{1'b1,1'b1,16'h0008,8'hFF,64'h0000_0001_0000_0003,64'h0,1'b0,8'd7},        // R7 split slots
    '{1'b0,1'b1,16'h0008,8'h00,64'h0,64'h0000_0001_0000_0001,1'b0,8'd7},        // R7
    '{1'b1,1'b0,16'h0010,8'h0F,64'h1,64'h0,1'b0,8'd8},                          // R8 missing hart
    '{1'b0,1'b0,16'h0010,8'h00,64'h0,64'h0,1'b0,8'd8},                          // R8
    '{1'b0,1'b0,16'h4020,8'h00,64'h0,64'h0,1'b0,8'd8},                          // R8 compare
    '{1'b1,1'b0,16'h4008,8'h03,64'h1234_5678,64'h0,1'b0,8'd6},                  // R6 partial strobe
    '{1'b0,1'b0,16'h4008,8'h00,64'h0,64'hFFFF_5678,1'b0,8'd6},                  // R6
    '{1'b1,1'b0,16'h8000,8'h0F,64'h5,64'h0,1'b0,8'd9},                          // R9 hole
    '{1'b0,1'b0,16'h8000,8'h00,64'h0,64'h0,1'b0,8'd9},                          // R9
    '{1'b0,1'b0,16'hC000,8'h00,64'h0,64'h0,1'b1,8'd10},                         // R10
    '{1'b0,1'b1,16'hBFFC,8'h00,64'h0,64'h0,1'b1,8'd10},                         // R10 wide over end
    '{1'b1,1'b1,16'hBFFC,8'hFF,64'hFFFF_FFFF_FFFF_FFFF,64'h0,1'b1,8'd10},       // R10 write
    '{1'b0,1'b0,16'hBFFC,8'h00,64'h0,64'h0,1'b0,8'd10},                         // R10 unchanged
    '{1'b0,1'b0,16'h4003,8'h00,64'h0,64'h10,1'b0,8'd11},                        // R11 low bits
    '{1'b1,1'b1,16'h3FFC,8'hFF,64'h0000_0020_0000_0001,64'h0,1'b0,8'd7},        // R7 cross region
    '{1'b0,1'b0,16'h4000,8'h00,64'h0,64'h20,1'b0,8'd7}                          // R7
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // drive at a falling edge; response registered at the next rising edge
  task automatic access(input logic wr, input logic wide, input logic [15:0] addr,
                        input logic [7:0] strb, input logic [63:0] wdata,
                        output logic [63:0] rd, output logic er, output logic vld);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_wide = wide;
    req_addr = addr; req_strb = strb; req_wdata = wdata;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    rd = rsp_rdata; er = rsp_err; vld = rsp_valid;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] rd;
    logic er, vld;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 sip_o", 64'(sip_o), 64'h0);
    chk("R1 tip_o", 64'(tip_o), 64'h0);
    chk("R1 rsp_valid", 64'(rsp_valid), 64'h0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i].wr, VEC[i].wide, VEC[i].addr, VEC[i].strb, VEC[i].wdata, rd, er, vld);
      chk($sformatf("R%0d row%0d rdata", VEC[i].req, i), rd, VEC[i].exp);
      chk($sformatf("R%0d row%0d err", VEC[i].req, i), 64'(er), 64'(VEC[i].err));
      chk($sformatf("R11 row%0d valid", i), 64'(vld), 64'h1);
    end

    chk("R5 R7 sip_o", 64'(sip_o), 64'hE);
    chk("R1 tip_o idle", 64'(tip_o), 64'h0);

    // R2: five ticks of 8
    @(negedge clk);
    tick_en = 1'b1; tick_amt = 8'd8;
    repeat (5) @(negedge clk);
    tick_en = 1'b0;
    @(negedge clk);
    access(1'b0, 1'b1, 16'hBFF8, 8'h0, 64'h0, rd, er, vld);
    chk("R2 counter", rd, 64'd40);
    chk("R4 tip after ticks", 64'(tip_o), 64'h1);

    // R3: write and tick sampled on the same edge
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_wide = 1'b0;
    req_addr = 16'hBFF8; req_strb = 8'h0F; req_wdata = 64'd100;
    tick_en = 1'b1; tick_amt = 8'd3;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; tick_en = 1'b0;
    access(1'b0, 1'b1, 16'hBFF8, 8'h0, 64'h0, rd, er, vld);
    chk("R3 write beats tick", rd, 64'd100);

    // R4: compare write, pending one edge later
    access(1'b1, 1'b1, 16'h4010, 8'hFF, 64'd100, rd, er, vld);
    chk("R4 tip before", 64'(tip_o[2]), 64'h0);
    @(negedge clk);
    chk("R4 tip after", 64'(tip_o[2]), 64'h1);

    // R4 unsigned: top bit of counter set
    access(1'b1, 1'b0, 16'hBFFC, 8'h0F, 64'h8000_0000, rd, er, vld);
    @(negedge clk);
    chk("R4 unsigned", 64'(tip_o), 64'h5);
    access(1'b0, 1'b1, 16'hBFF8, 8'h0, 64'h0, rd, er, vld);
    chk("R3 high word", rd, 64'h8000_0000_0000_0064);

    // R5: clear via aligned strobe
    access(1'b1, 1'b0, 16'h0004, 8'h01, 64'h0, rd, er, vld);
    @(negedge clk);
    chk("R5 clear hart1", 64'(sip_o), 64'hC);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule